// File: doc/BRIEF.md
# Radio Control State Sequencer

This block is the main control state machine of a transmit path. It reacts to one-cycle command strobes: a soft reset, a start-transmit and a transmit-buffer flush. A start-transmit issued while the machine is idle walks it through an optional calibration phase, a bandwidth-boost phase and a synthesizer-lock wait before it transmits. The current state is always visible on an 8-bit state code, which software reads as a status value.

Calibration, the synthesizer and the modulator are not modelled. The calibration and boost phases last a fixed, parameterised number of cycles. Lock, transmit-buffer emptiness and end of packet arrive as input flags. When the transmit buffer runs dry before the packet ends, the machine parks in an underflow state until a flush or reset clears it. An accepted flush raises a one-cycle flush request toward the buffer.

Top module: `radio_seq`

## Requirements
- R1: After `rst_n` is released, `state_code` is 0x01 (idle) and `flush_req` is 0.
- R2: A strobe with code 0x35 in idle, with `autocal_mode` equal to 2'b01, moves the machine to 0x08 (calibrating). It stays there for exactly CAL_CYCLES cycles and then moves to 0x09 (boost).
- R3: A strobe with code 0x35 in idle, with `autocal_mode` set to any value other than 2'b01, moves the machine straight to 0x09, skipping calibration.
- R4: State 0x09 lasts exactly BOOST_CYCLES cycles and then moves to 0x0A (lock wait), whatever `pll_locked` does during that time.
- R5: In 0x0A the machine stays until `pll_locked` is sampled high, then moves to 0x13 (transmitting) on that same edge.
- R6: In 0x13, `packet_done` returns the machine to 0x01. This takes priority over `tx_fifo_empty`.
- R7: In 0x13, `tx_fifo_empty` high with `packet_done` low moves the machine to 0x16 (underflow). It leaves 0x16 only on a flush or reset strobe; a start-transmit strobe there is ignored.
- R8: A strobe with code 0x3B in 0x01 or 0x16 is accepted. `flush_req` is high for exactly the one cycle after the accepting edge, and from 0x16 the machine moves to 0x01.
- R9: A strobe with code 0x3B in any other state is ignored. `flush_req` stays 0 and the state does not change.
- R10: A strobe with code 0x30 returns the machine to 0x01 on the next edge, from any state.
- R11: A start-transmit strobe outside idle has no effect, and so does a strobe with any code other than 0x30, 0x35 or 0x3B.
- R12: Driving `rst_n` low forces 0x01 at once, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_valid | input | 1 | One-cycle command strobe qualifier |
| strobe_code | input | 6 | Command code (0x30 reset, 0x35 transmit, 0x3B flush) |
| autocal_mode | input | 2 | Auto-calibration field; 2'b01 means calibrate when leaving idle |
| pll_locked | input | 1 | Synthesizer lock indication |
| tx_fifo_empty | input | 1 | Transmit buffer is empty |
| packet_done | input | 1 | Current packet has been fully sent |
| state_code | output | 8 | Current state code |
| flush_req | output | 1 | One-cycle request to flush the transmit buffer |

## Verification
Every internal state maps one-to-one onto `state_code`, so a wrong transition shows at the port on the edge that makes it. A timing error in calibration or boost (an extra or missing cycle) shows as the code changing one sample early or late. A wrongly accepted or rejected flush shows on `flush_req` in the cycle after the strobe. Each walk through the sequence is compared against `state_code` after every clock edge, so any deviation is caught within one cycle.

// File: rtl/radio_seq.sv
module radio_seq #(
  parameter int CAL_CYCLES   = 4,
  parameter int BOOST_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_valid,
  input  logic [5:0] strobe_code,
  input  logic [1:0] autocal_mode,
  input  logic       pll_locked,
  input  logic       tx_fifo_empty,
  input  logic       packet_done,
  output logic [7:0] state_code,
  output logic       flush_req
);

  localparam int MAXC = (CAL_CYCLES > BOOST_CYCLES) ? CAL_CYCLES : BOOST_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [5:0] CMD_RST   = 6'h30;
  localparam logic [5:0] CMD_TX    = 6'h35;
  localparam logic [5:0] CMD_FLUSH = 6'h3B;
  localparam logic [1:0] CAL_ON_LEAVE = 2'b01;

  typedef enum logic [7:0] {
    S_IDLE  = 8'h01,
    S_CAL   = 8'h08,
    S_BOOST = 8'h09,
    S_LOCK  = 8'h0A,
    S_TX    = 8'h13,
    S_UFLOW = 8'h16
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt;

  wire do_rst   = strobe_valid && (strobe_code == CMD_RST);
  wire do_tx    = strobe_valid && (strobe_code == CMD_TX);
  wire do_flush = strobe_valid && (strobe_code == CMD_FLUSH);
  wire flush_ok = do_flush && (st == S_IDLE || st == S_UFLOW);
  wire cal_end  = (cnt == CW'(CAL_CYCLES - 1));
  wire boost_end = (cnt == CW'(BOOST_CYCLES - 1));

  always_comb begin
    nx = st;
    if (do_rst) nx = S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (do_tx) nx = (autocal_mode == CAL_ON_LEAVE) ? S_CAL : S_BOOST;
        S_CAL:   if (cal_end) nx = S_BOOST;
        S_BOOST: if (boost_end) nx = S_LOCK;
        S_LOCK:  if (pll_locked) nx = S_TX;
        S_TX:    if (packet_done) nx = S_IDLE;
                 else if (tx_fifo_empty) nx = S_UFLOW;
        S_UFLOW: if (flush_ok) nx = S_IDLE;
        default: nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      flush_req <= 1'b0;
    end else begin
      st        <= nx;
      flush_req <= flush_ok;
      if (nx != st) cnt <= '0;
      else if (st == S_CAL || st == S_BOOST) cnt <= cnt + 1'b1;
    end
  end

  assign state_code = st;

  AST_CAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && do_tx && autocal_mode == CAL_ON_LEAVE) |=> state_code == 8'h08); // R2
  AST_SKIP_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && do_tx && autocal_mode != CAL_ON_LEAVE) |=> state_code == 8'h09); // R3
  AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK && !pll_locked && !do_rst) |=> state_code == 8'h0A); // R5
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && packet_done) |=> state_code == 8'h01); // R6
  AST_UFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UFLOW && !do_rst && !do_flush) |=> state_code == 8'h16); // R7
  AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> ($past(state_code) == 8'h01 || $past(state_code) == 8'h16)); // R9
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req || $past(do_flush)); // R8
  AST_RESET_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    do_rst |=> state_code == 8'h01); // R10

endmodule

// File: tb/tb_radio_seq.sv
module tb_radio_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_valid = 1'b0;
  logic [5:0] strobe_code = '0;
  logic [1:0] autocal_mode = '0;
  logic pll_locked = 1'b0;
  logic tx_fifo_empty = 1'b0;
  logic packet_done = 1'b0;
  logic [7:0] state_code;
  logic flush_req;

  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  radio_seq #(.CAL_CYCLES(4), .BOOST_CYCLES(2)) dut (
    .clk(clk), .rst_n(rst_n), .strobe_valid(strobe_valid), .strobe_code(strobe_code),
    .autocal_mode(autocal_mode), .pll_locked(pll_locked), .tx_fifo_empty(tx_fifo_empty),
    .packet_done(packet_done), .state_code(state_code), .flush_req(flush_req));

  localparam logic [5:0] NO = 6'h00, TX = 6'h35, FL = 6'h3B, RS = 6'h30, XX = 6'h3A;
  localparam int VW = 25;
  localparam int NV = 38;

  function automatic logic [VW-1:0] v(input int rq, input logic sv, input logic [5:0] c,
      input logic [1:0] m, input logic lk, input logic em, input logic dn,
      input logic [7:0] es, input logic ef);
    return {4'(rq), sv, c, m, lk, em, dn, es, ef};
  endfunction

  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    v(1,0,NO,2'b01,0,0,0,8'h01,0),   // R1
    v(2,1,TX,2'b01,0,0,0,8'h08,0),   // R2
    v(2,0,NO,2'b01,0,0,0,8'h08,0),
    v(2,0,NO,2'b01,1,0,0,8'h08,0),
    v(2,0,NO,2'b01,0,0,0,8'h08,0),
    v(2,0,NO,2'b01,0,0,0,8'h09,0),
    v(4,0,NO,2'b01,1,0,0,8'h09,0),   // R4
    v(4,0,NO,2'b01,0,0,0,8'h0A,0),
    v(5,0,NO,2'b01,0,0,0,8'h0A,0),   // R5
    v(5,0,NO,2'b01,1,0,0,8'h13,0),
    v(6,0,NO,2'b01,0,0,0,8'h13,0),
    v(6,0,NO,2'b01,0,0,1,8'h01,0),   // R6
    v(3,1,TX,2'b00,0,0,0,8'h09,0),   // R3
    v(4,0,NO,2'b00,0,0,0,8'h09,0),
    v(4,0,NO,2'b00,0,0,0,8'h0A,0),
    v(5,0,NO,2'b00,1,0,0,8'h13,0),
    v(9,1,FL,2'b00,0,0,0,8'h13,0),   // R9
    v(7,0,NO,2'b00,0,1,0,8'h16,0),   // R7
    v(7,1,TX,2'b00,0,1,0,8'h16,0),
    v(8,1,FL,2'b00,0,1,0,8'h01,1),   // R8
    v(8,0,NO,2'b00,0,0,0,8'h01,0),
    v(8,1,FL,2'b00,0,0,0,8'h01,1),
    v(3,1,TX,2'b10,0,0,0,8'h09,0),
    v(11,1,TX,2'b10,0,0,0,8'h09,0),  // R11
    v(10,1,RS,2'b10,0,0,0,8'h01,0),  // R10
    v(2,1,TX,2'b01,0,0,0,8'h08,0),
    v(10,1,RS,2'b01,0,0,0,8'h01,0),
    v(3,1,TX,2'b11,0,0,0,8'h09,0),
    v(4,0,NO,2'b11,0,0,0,8'h09,0),
    v(4,0,NO,2'b11,1,0,0,8'h0A,0),
    v(5,0,NO,2'b11,1,0,0,8'h13,0),
    v(6,0,NO,2'b11,0,1,1,8'h01,0),
    v(2,1,TX,2'b01,0,0,0,8'h08,0),
    v(9,1,FL,2'b01,0,0,0,8'h08,0),
    v(2,0,NO,2'b01,0,0,0,8'h08,0),
    v(2,0,NO,2'b01,0,0,0,8'h08,0),
    v(2,0,NO,2'b01,0,0,0,8'h09,0),
    v(10,1,RS,2'b01,0,0,0,8'h01,0)
  };

  task automatic check(input int rq, input logic [7:0] es, input logic ef);
    checks++;
    if (state_code !== es || flush_req !== ef) begin
      fails++;
      $display("FAIL R%0d: state=%02h flush=%0b expected state=%02h flush=%0b",
               rq, state_code, flush_req, es, ef);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(12, 8'h01, 1'b0);          // R12 during reset
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(1, 8'h01, 1'b0);           // R1
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {strobe_valid, strobe_code, autocal_mode, pll_locked, tx_fifo_empty, packet_done}
        = VEC[i][20:9];
      step();
      check(int'(VEC[i][24:21]), VEC[i][8:1], VEC[i][0]);
    end
    // R11: unknown code in idle
    @(negedge clk);
    {strobe_valid, strobe_code, pll_locked, tx_fifo_empty, packet_done} = {1'b1, XX, 3'b000};
    step();
    check(11, 8'h01, 1'b0);
    // R5: lock already high when lock wait is entered
    @(negedge clk);
    {strobe_valid, strobe_code, autocal_mode, pll_locked} = {1'b1, TX, 2'b00, 1'b1};
    step();
    @(negedge clk) strobe_valid = 1'b0;
    step(); step();
    check(5, 8'h0A, 1'b0);
    step();
    check(5, 8'h13, 1'b0);
    // R12: asynchronous reset in transmit
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(12, 8'h01, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    pll_locked = 1'b0;
    step();
    check(12, 8'h01, 1'b0);
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule